// File: doc/BRIEF.md
# Baseband DSP Serial Port

A bidirectional 16-bit synchronous serial link between a baseband converter and a DSP. The receive direction has its own clock, frame-sync and data lines. Its clock is either generated here by dividing the master clock by three, or supplied by the DSP, which may send it in bursts. The downlink direction always generates its own clock, frame sync and data toward the DSP. Both directions keep a shift register and a separate holding word, so that words can stream back to back without a gap.

The block runs on one system clock `clk` at twice the master clock rate. Every serial pin is produced or sampled in that domain. The internal receive clock is `clk`/6, which is the master clock divided by three. The downlink clock is `clk`/2, which equals the master clock. Frame sync is one serial period wide and is high during the period before the MSB. Data is MSB first. The DSP samples on falling clock edges, and this block changes its outputs on rising edges. The holding word on the receive side is handed to internal logic with a one-cycle strobe and freed with an acknowledge.

Top module: `bsp_port`

## Requirements
- R1: After reset: the receive clock pin is driven (`rxclk_oe`=1), `tx_empty`=1, `rx_valid`=0, `rx_overrun`=0, and `txclk_o`, `tx_fs_o` and `tx_d_o` are 0.
- R2: When `cfg_rxclk_ext`=0, `rxclk_o` runs without stopping, with a period of RX_DIV `clk` cycles: high for RX_DIV/2 cycles, then low for the rest (3 and 3 by default).
- R3: A receive word starts when `rx_fs_i`=1 is sampled on a falling receive-clock edge. The next 16 falling edges sample `rx_d_i`, MSB first. The word is not presented after the LSB edge. It is presented on `rx_word` with a one-cycle `rx_valid` only on the next falling edge after the LSB.
- R4: A frame sync sampled on the LSB edge of a word starts the next word with no gap, and both words are delivered in order.
- R5: When `cfg_rxclk_ext`=1, `rxclk_oe`=0, and the falling edges of `rxclk_i` (after a two-stage synchronizer, with `rx_fs_i` and `rx_d_i` delayed alike) take the place of the internal clock. The clock may stop low between and inside words.
- R6: If a word reaches the holding register while the previous word is still unacknowledged (`rx_ack` not seen since its `rx_valid`), `rx_overrun` is set. The new word replaces the old one. `rx_overrun` stays set until reset, and `rx_ack` does not clear it.
- R7: Writing a word with `tx_load` clears `tx_empty`. Next comes one full downlink clock period without frame sync, then one period with `tx_fs_o`=1, then 16 periods carrying the word MSB first. `txclk_o` has a period of 2 `clk` cycles, and `tx_fs_o` and `tx_d_o` change only together with a rising `txclk_o`.
- R8: If the next word is loaded before the LSB period of the current word begins, its frame sync is raised during that LSB period, and its MSB follows directly. The two frame syncs are 16 periods apart.
- R9: With `cfg_tx_cont`=0, `txclk_o` stays low while no word is in flight. With `cfg_tx_cont`=1, it toggles every `clk` cycle even when idle.
- R10: With `cfg_idle_hiz`=1, `tx_oe`=0 while the downlink is idle and 1 while a sequence runs. With `cfg_idle_hiz`=0, `tx_oe` stays 1 and idle `tx_fs_o` and `tx_d_o` are 0. Frame sync is never high while `tx_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the master clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rxclk_ext | input | 1 | 1: receive clock comes from the DSP on `rxclk_i` |
| cfg_tx_cont | input | 1 | 1: downlink clock runs continuously |
| cfg_idle_hiz | input | 1 | 1: release downlink pins while idle |
| rxclk_i | input | 1 | External receive clock |
| rxclk_o | output | 1 | Internally generated receive clock |
| rxclk_oe | output | 1 | Drive enable for the receive clock pin |
| rx_fs_i | input | 1 | Receive frame sync |
| rx_d_i | input | 1 | Receive serial data |
| rx_word | output | W | Received holding word |
| rx_valid | output | 1 | One-cycle strobe: new word in `rx_word` |
| rx_ack | input | 1 | Internal logic has taken the holding word |
| rx_overrun | output | 1 | Sticky receive overrun |
| tx_word | input | W | Word to send |
| tx_load | input | 1 | Write `tx_word` into the downlink buffer |
| tx_empty | output | 1 | Downlink buffer can take a word |
| txclk_o | output | 1 | Downlink clock |
| tx_fs_o | output | 1 | Downlink frame sync |
| tx_d_o | output | 1 | Downlink data |
| tx_oe | output | 1 | Drive enable for the downlink pins |

## Verification
The hardest case to reach is a word boundary that carries two events on one edge. In the receive direction, the LSB edge of one word also samples the next frame sync. In the downlink direction, a buffered word has to be captured in the same period in which the LSB leaves. The bench drives the receive pins slot by slot, one value per observed falling clock edge, so it can place a frame sync exactly on an LSB slot. It loads the second downlink word as soon as `tx_empty` returns, well inside the first word's data periods. It then checks the spacing between the frame syncs it decodes, counted in falling edges. The overrun case is reached by switching off the bench's automatic acknowledge across two complete receive words.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_PRE  = 2'd1,
    TX_SYNC = 2'd2,
    TX_DATA = 2'd3
  } tx_state_e;
endpackage

// File: rtl/bsp_rx_clk.sv
// Receive clock source: internal divider or synchronized external clock.
// Produces a falling-edge event and the fs/data values to sample with it.
module bsp_rx_clk #(
  parameter int RX_DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_sel,
  input  logic pin_clk,
  input  logic pin_fs,
  input  logic pin_d,
  output logic clk_out,
  output logic fall_ev,
  output logic smp_fs,
  output logic smp_d
);
  localparam int CW   = (RX_DIV > 2) ? $clog2(RX_DIV) : 1;
  localparam int HALF = RX_DIV / 2;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          clk_q;
  logic [2:0]    clk_s_q;
  logic [1:0]    fs_s_q, d_s_q;
  logic          int_fall, ext_fall;

  always_comb begin
    cnt_d    = (cnt_q == CW'(RX_DIV - 1)) ? '0 : cnt_q + 1'b1;
    int_fall = (cnt_d == CW'(HALF));
    ext_fall = clk_s_q[2] & ~clk_s_q[1];
    fall_ev  = ext_sel ? ext_fall : int_fall;
    smp_fs   = ext_sel ? fs_s_q[1] : pin_fs;
    smp_d    = ext_sel ? d_s_q[1]  : pin_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      clk_q   <= 1'b0;
      clk_s_q <= '0;
      fs_s_q  <= '0;
      d_s_q   <= '0;
    end else begin
      cnt_q   <= cnt_d;
      clk_q   <= (cnt_d < CW'(HALF));
      clk_s_q <= {clk_s_q[1:0], pin_clk};
      fs_s_q  <= {fs_s_q[0], pin_fs};
      d_s_q   <= {d_s_q[0], pin_d};
    end
  end

  assign clk_out = clk_q;
endmodule

// File: rtl/bsp_rx_deser.sv
// Receive shift register, staging word (one extra edge) and holding word.
module bsp_rx_deser #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev,
  input  logic         s_fs,
  input  logic         s_d,
  input  logic         ack,
  output logic [W-1:0] word,
  output logic         valid,
  output logic         overrun
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sr_q, sr_d, stg_q, stg_d, hold_q, hold_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d, stg_vld_q, stg_vld_d;
  logic          full_q, full_d, vld_q, vld_d, ovr_q, ovr_d;

  always_comb begin
    sr_d      = sr_q;
    stg_d     = stg_q;
    hold_d    = hold_q;
    cnt_d     = cnt_q;
    act_d     = act_q;
    stg_vld_d = stg_vld_q;
    full_d    = full_q;
    vld_d     = 1'b0;
    ovr_d     = ovr_q;
    if (ack) full_d = 1'b0;
    if (ev) begin
      if (stg_vld_q) begin
        hold_d    = stg_q;
        full_d    = 1'b1;
        vld_d     = 1'b1;
        stg_vld_d = 1'b0;
        if (full_q && !ack) ovr_d = 1'b1;
      end
      if (act_q) begin
        sr_d  = {sr_q[W-2:0], s_d};
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          stg_d     = {sr_q[W-2:0], s_d};
          stg_vld_d = 1'b1;
          act_d     = 1'b0;
        end
      end
      if (s_fs) begin
        act_d = 1'b1;
        cnt_d = CW'(W);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q      <= '0;
      stg_q     <= '0;
      hold_q    <= '0;
      cnt_q     <= '0;
      act_q     <= 1'b0;
      stg_vld_q <= 1'b0;
      full_q    <= 1'b0;
      vld_q     <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      sr_q      <= sr_d;
      stg_q     <= stg_d;
      hold_q    <= hold_d;
      cnt_q     <= cnt_d;
      act_q     <= act_d;
      stg_vld_q <= stg_vld_d;
      full_q    <= full_d;
      vld_q     <= vld_d;
      ovr_q     <= ovr_d;
    end
  end

  assign word    = hold_q;
  assign valid   = vld_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/bsp_tx_ser.sv
// Downlink serializer: buffer, shift register, clock, frame sync, idle control.
module bsp_tx_ser
  import bsp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cont,
  input  logic         idle_hiz,
  input  logic         ld,
  input  logic [W-1:0] ld_word,
  output logic         empty,
  output logic         sclk,
  output logic         fs,
  output logic         d,
  output logic         oe
);
  localparam int CW = $clog2(W);

  tx_state_e     st_q, st_d;
  logic          ph_q, ph_d, adv;
  logic [W-1:0]  buf_q, buf_d, sr_q, sr_d;
  logic [CW-1:0] bit_q, bit_d;
  logic          full_q, full_d, chain_q, chain_d, fs_q, fs_d, d_q, d_d;

  always_comb begin
    st_d    = st_q;
    buf_d   = buf_q;
    sr_d    = sr_q;
    bit_d   = bit_q;
    full_d  = full_q;
    chain_d = chain_q;
    fs_d    = fs_q;
    d_d     = d_q;
    adv     = !ph_q && ((st_q != TX_IDLE) || cont || full_q);
    ph_d    = adv;
    if (adv) begin
      unique case (st_q)
        TX_IDLE: begin
          if (full_q) st_d = TX_PRE;
          fs_d = 1'b0;
          d_d  = 1'b0;
        end
        TX_PRE: begin
          st_d   = TX_SYNC;
          fs_d   = 1'b1;
          sr_d   = buf_q;
          full_d = 1'b0;
        end
        TX_SYNC: begin
          st_d  = TX_DATA;
          fs_d  = 1'b0;
          d_d   = sr_q[W-1];
          sr_d  = sr_q << 1;
          bit_d = CW'(W - 1);
        end
        default: begin
          if (bit_q != '0) begin
            d_d   = sr_q[W-1];
            sr_d  = sr_q << 1;
            bit_d = bit_q - 1'b1;
            fs_d  = 1'b0;
            if (bit_q == CW'(1) && full_q) begin
              fs_d    = 1'b1;
              chain_d = 1'b1;
              sr_d    = buf_q;
              full_d  = 1'b0;
            end
          end else if (chain_q) begin
            fs_d    = 1'b0;
            d_d     = sr_q[W-1];
            sr_d    = sr_q << 1;
            bit_d   = CW'(W - 1);
            chain_d = 1'b0;
          end else begin
            st_d = TX_IDLE;
            fs_d = 1'b0;
            d_d  = 1'b0;
          end
        end
      endcase
    end
    if (ld) begin
      buf_d  = ld_word;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= TX_IDLE;
      ph_q    <= 1'b0;
      buf_q   <= '0;
      sr_q    <= '0;
      bit_q   <= '0;
      full_q  <= 1'b0;
      chain_q <= 1'b0;
      fs_q    <= 1'b0;
      d_q     <= 1'b0;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      buf_q   <= buf_d;
      sr_q    <= sr_d;
      bit_q   <= bit_d;
      full_q  <= full_d;
      chain_q <= chain_d;
      fs_q    <= fs_d;
      d_q     <= d_d;
    end
  end

  assign empty = !full_q;
  assign sclk  = ph_q;
  assign fs    = fs_q;
  assign d     = d_q;
  assign oe    = !(idle_hiz && (st_q == TX_IDLE));
endmodule

// File: rtl/bsp_port.sv
module bsp_port #(
  parameter int W      = 16,
  parameter int RX_DIV = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_rxclk_ext,
  input  logic         cfg_tx_cont,
  input  logic         cfg_idle_hiz,
  input  logic         rxclk_i,
  output logic         rxclk_o,
  output logic         rxclk_oe,
  input  logic         rx_fs_i,
  input  logic         rx_d_i,
  output logic [W-1:0] rx_word,
  output logic         rx_valid,
  input  logic         rx_ack,
  output logic         rx_overrun,
  input  logic [W-1:0] tx_word,
  input  logic         tx_load,
  output logic         tx_empty,
  output logic         txclk_o,
  output logic         tx_fs_o,
  output logic         tx_d_o,
  output logic         tx_oe
);
  logic [1:0] rst_sync_q;
  logic       srst_n;
  logic       fall_ev, smp_fs, smp_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n   = rst_sync_q[1];
  assign rxclk_oe = !cfg_rxclk_ext;

  bsp_rx_clk #(.RX_DIV(RX_DIV)) u_rxclk (
    .clk(clk), .rst_n(srst_n), .ext_sel(cfg_rxclk_ext),
    .pin_clk(rxclk_i), .pin_fs(rx_fs_i), .pin_d(rx_d_i),
    .clk_out(rxclk_o), .fall_ev(fall_ev), .smp_fs(smp_fs), .smp_d(smp_d)
  );

  bsp_rx_deser #(.W(W)) u_rx (
    .clk(clk), .rst_n(srst_n), .ev(fall_ev), .s_fs(smp_fs), .s_d(smp_d),
    .ack(rx_ack), .word(rx_word), .valid(rx_valid), .overrun(rx_overrun)
  );

  bsp_tx_ser #(.W(W)) u_tx (
    .clk(clk), .rst_n(srst_n), .cont(cfg_tx_cont), .idle_hiz(cfg_idle_hiz),
    .ld(tx_load), .ld_word(tx_word), .empty(tx_empty),
    .sclk(txclk_o), .fs(tx_fs_o), .d(tx_d_o), .oe(tx_oe)
  );
endmodule

// File: rtl/bsp_port_chk.sv
module bsp_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_rxclk_ext,
  input logic rxclk_o,
  input logic rx_valid,
  input logic rx_overrun,
  input logic txclk_o,
  input logic tx_fs_o,
  input logic tx_d_o,
  input logic tx_oe
);
  assert_rxclk_low_hold_R2: assert property (@(posedge clk)
    disable iff (!rst_n || cfg_rxclk_ext) $fell(rxclk_o) |=> !rxclk_o);

  assert_rxclk_high_hold_R2: assert property (@(posedge clk)
    disable iff (!rst_n || cfg_rxclk_ext) $rose(rxclk_o) |=> rxclk_o);

  assert_strobe_single_R3: assert property (@(posedge clk)
    disable iff (!rst_n) rx_valid |=> !rx_valid);

  assert_overrun_sticky_R6: assert property (@(posedge clk)
    disable iff (!rst_n) rx_overrun |=> rx_overrun);

  assert_txclk_half_R7: assert property (@(posedge clk)
    disable iff (!rst_n) $rose(txclk_o) |=> !txclk_o);

  assert_fs_on_rise_R7: assert property (@(posedge clk)
    disable iff (!rst_n) $rose(tx_fs_o) |-> $rose(txclk_o));

  assert_data_on_rise_R7: assert property (@(posedge clk)
    disable iff (!rst_n) !$stable(tx_d_o) |-> $rose(txclk_o));

  assert_fs_driven_R10: assert property (@(posedge clk)
    disable iff (!rst_n) tx_fs_o |-> tx_oe);
endmodule

bind bsp_port bsp_port_chk u_chk (.*);

// File: tb/sim_bsp_port.sv
module sim_bsp_port;
  logic        clk, rst_n;
  logic        cfg_rxclk_ext, cfg_tx_cont, cfg_idle_hiz;
  logic        rxclk_i, rxclk_o, rxclk_oe, rx_fs_i, rx_d_i;
  logic [15:0] rx_word, tx_word;
  logic        rx_valid, rx_ack, rx_overrun;
  logic        tx_load, tx_empty, txclk_o, tx_fs_o, tx_d_o, tx_oe;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] got [0:15];
  int gn = 0;
  logic [15:0] txw [0:15];
  int txn = 0;
  int fsi [0:15];
  int fsn = 0;
  int fall_idx = 0;
  int tx_cnt = 0;
  logic [15:0] tx_sr = '0;
  logic prev_tclk = 1'b0;
  logic auto_ack = 1'b1;
  logic ack_req = 1'b0;
  logic wd = 1'b0;

  bsp_port u0 (
    .clk(clk), .rst_n(rst_n), .cfg_rxclk_ext(cfg_rxclk_ext),
    .cfg_tx_cont(cfg_tx_cont), .cfg_idle_hiz(cfg_idle_hiz),
    .rxclk_i(rxclk_i), .rxclk_o(rxclk_o), .rxclk_oe(rxclk_oe),
    .rx_fs_i(rx_fs_i), .rx_d_i(rx_d_i), .rx_word(rx_word),
    .rx_valid(rx_valid), .rx_ack(rx_ack), .rx_overrun(rx_overrun),
    .tx_word(tx_word), .tx_load(tx_load), .tx_empty(tx_empty),
    .txclk_o(txclk_o), .tx_fs_o(tx_fs_o), .tx_d_o(tx_d_o), .tx_oe(tx_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Monitor: receive strobes, acknowledge, downlink decoder.
  always @(negedge clk) begin
    if (rx_valid) begin
      got[gn & 15] = rx_word;
      gn++;
    end
    rx_ack = (rx_valid && auto_ack) || ack_req;
    if (prev_tclk && !txclk_o) begin
      if (tx_cnt != 0) begin
        tx_sr = {tx_sr[14:0], tx_d_o};
        tx_cnt--;
        if (tx_cnt == 0) begin
          txw[txn & 15] = tx_sr;
          txn++;
        end
      end
      if (tx_fs_o) begin
        fsi[fsn & 15] = fall_idx;
        fsn++;
        tx_cnt = 16;
      end
      fall_idx++;
    end
    prev_tclk = txclk_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rx_slot(input logic fs, input logic dv);
    rx_fs_i = fs;
    rx_d_i  = dv;
    if (cfg_rxclk_ext) begin
      rxclk_i = 1'b1;
      repeat (4) @(negedge clk);
      rxclk_i = 1'b0;
      repeat (4) @(negedge clk);
    end else begin
      for (int i = 0; i < 50; i++) begin @(negedge clk); if (rxclk_o) break; end
      for (int i = 0; i < 50; i++) begin @(negedge clk); if (!rxclk_o) break; end
    end
  endtask

  task automatic rx_frame(input logic [15:0] w, input logic fs_on_lsb);
    for (int i = 15; i >= 0; i--) rx_slot((i == 0) && fs_on_lsb, w[i]);
  endtask

  task automatic tx_put(input logic [15:0] w);
    tx_word = w;
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  task automatic wait_txn(input int target);
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (txn >= target) break; end
  endtask

  task automatic t_reset;
    chk("R1 rxclk_oe", rxclk_oe, 1);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 rx_valid count", gn, 0);
    chk("R1 rx_overrun", rx_overrun, 0);
    chk("R1 txclk/fs/d", {txclk_o, tx_fs_o, tx_d_o}, 0);
  endtask

  task automatic t_rx_clock;
    int hi = 0, lo = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (!rxclk_o) break; end
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (rxclk_o) break; end
    while (rxclk_o && hi < 20) begin hi++; @(negedge clk); end
    while (!rxclk_o && lo < 20) begin lo++; @(negedge clk); end
    chk("R2 rxclk high cycles", hi, 3);
    chk("R2 rxclk low cycles", lo, 3);
  endtask

  task automatic t_rx_word;
    int g0 = gn;
    rx_slot(1'b1, 1'b0);
    rx_frame(16'hA5C3, 1'b0);
    repeat (2) @(negedge clk);
    chk("R3 no word before extra edge", gn - g0, 0);
    rx_slot(1'b0, 1'b0);
    repeat (2) @(negedge clk);
    chk("R3 one strobe after extra edge", gn - g0, 1);
    chk("R3 word MSB first", got[g0 & 15], 16'hA5C3);
  endtask

  task automatic t_rx_b2b;
    int g0 = gn;
    rx_slot(1'b1, 1'b0);
    rx_frame(16'h1234, 1'b1);
    rx_frame(16'hFEDC, 1'b0);
    rx_slot(1'b0, 1'b0);
    repeat (2) @(negedge clk);
    chk("R4 two words", gn - g0, 2);
    chk("R4 first word", got[g0 & 15], 16'h1234);
    chk("R4 second word", got[(g0 + 1) & 15], 16'hFEDC);
    chk("R4 no overrun", rx_overrun, 0);
  endtask

  task automatic t_rx_ext;
    int g0 = gn;
    logic [15:0] w = 16'h0F96;
    cfg_rxclk_ext = 1'b1;
    rxclk_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 rxclk pin released", rxclk_oe, 0);
    rx_slot(1'b1, 1'b0);
    for (int i = 15; i >= 0; i--) begin
      rx_slot(1'b0, w[i]);
      if (i == 9) repeat (25) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    chk("R5 no word during burst gap", gn - g0, 0);
    rx_slot(1'b0, 1'b0);
    repeat (2) @(negedge clk);
    chk("R5 external-clock word", got[g0 & 15], w);
    cfg_rxclk_ext = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_rx_overrun;
    auto_ack = 1'b0;
    rx_slot(1'b1, 1'b0);
    rx_frame(16'h5555, 1'b0);
    rx_slot(1'b0, 1'b0);
    repeat (2) @(negedge clk);
    chk("R6 no overrun on first word", rx_overrun, 0);
    rx_slot(1'b1, 1'b0);
    rx_frame(16'h3C3C, 1'b0);
    rx_slot(1'b0, 1'b0);
    repeat (2) @(negedge clk);
    chk("R6 overrun set", rx_overrun, 1);
    chk("R6 newer word kept", rx_word, 16'h3C3C);
    ack_req = 1'b1;
    repeat (2) @(negedge clk);
    ack_req = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 overrun sticky after ack", rx_overrun, 1);
    auto_ack = 1'b1;
  endtask

  task automatic t_tx_single;
    int base, f0, n0;
    repeat (4) @(negedge clk);
    base = fall_idx; f0 = fsn; n0 = txn;
    tx_put(16'hC0DE);
    chk("R7 buffer taken flag", tx_empty, 0);
    wait_txn(n0 + 1);
    chk("R7 word sent MSB first", txw[n0 & 15], 16'hC0DE);
    chk("R7 one extra period before sync", fsi[f0 & 15] - base, 1);
    chk("R7 single frame sync", fsn - f0, 1);
    chk("R7 buffer empty again", tx_empty, 1);
  endtask

  task automatic t_tx_b2b;
    int f0, n0;
    repeat (4) @(negedge clk);
    f0 = fsn; n0 = txn;
    tx_put(16'h8001);
    for (int i = 0; i < 50; i++) begin @(negedge clk); if (tx_empty) break; end
    tx_put(16'h6AB9);
    wait_txn(n0 + 2);
    chk("R8 first chained word", txw[n0 & 15], 16'h8001);
    chk("R8 second chained word", txw[(n0 + 1) & 15], 16'h6AB9);
    chk("R8 sync spacing no gap", fsi[(f0 + 1) & 15] - fsi[f0 & 15], 16);
  endtask

  task automatic t_tx_clkmode;
    int hi = 0, n0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (txclk_o) hi++; end
    chk("R9 burst idle clock low", hi, 0);
    cfg_tx_cont = 1'b1;
    repeat (2) @(negedge clk);
    hi = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (txclk_o) hi++; end
    chk("R9 continuous idle clock toggles", hi, 10);
    n0 = txn;
    tx_put(16'h2E71);
    wait_txn(n0 + 1);
    chk("R9 continuous mode word", txw[n0 & 15], 16'h2E71);
    cfg_tx_cont = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_idle;
    int n0;
    chk("R10 idle driven enable", tx_oe, 1);
    chk("R10 idle fs/d low", {tx_fs_o, tx_d_o}, 0);
    cfg_idle_hiz = 1'b1;
    @(negedge clk);
    chk("R10 idle released", tx_oe, 0);
    n0 = txn;
    tx_put(16'h9A0F);
    repeat (3) @(negedge clk);
    chk("R10 driven during sequence", tx_oe, 1);
    wait_txn(n0 + 1);
    repeat (4) @(negedge clk);
    chk("R10 word with release mode", txw[n0 & 15], 16'h9A0F);
    chk("R10 released after sequence", tx_oe, 0);
    cfg_idle_hiz = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_all;
    t_reset();
    t_rx_clock();
    t_rx_word();
    t_rx_b2b();
    t_rx_ext();
    t_rx_overrun();
    t_tx_single();
    t_tx_b2b();
    t_tx_clkmode();
    t_idle();
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_rxclk_ext = 1'b0; cfg_tx_cont = 1'b0; cfg_idle_hiz = 1'b0;
    rxclk_i = 1'b0; rx_fs_i = 1'b0; rx_d_i = 1'b0;
    tx_word = '0; tx_load = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    fork
      run_all();
      begin repeat (100000) @(posedge clk); wd = 1'b1; end
    join_any
    if (wd) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual expired expected completion");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule